// File: doc/BRIEF.md
# Ray-Major Polar Address Generator

This block walks a polar sampling grid and, for every grid point, emits the Cartesian cell that the point falls in. The grid has N rays and N radial samples per ray. The block finishes every sample of one ray before it starts the next ray, and the ray angle only ever increases. Along a ray, the Cartesian position moves by a fixed per-ray step, so the inner loop is a pair of additions. Between rays, the per-ray step vector is rotated by a constant small angle, using the angle-addition recurrence with host-supplied constants. Every division and trigonometric evaluation happens on the host before the job starts.

A host writes the job constants through an eight-entry write-only register port and then pulses `start`. The block streams one beat per accepted handshake. Each beat carries the integer and fractional parts of the x and y positions in unsigned 12.16 fixed point, plus the linear destination index. After the final point has been accepted, the block raises `done` and holds it until the next job starts. A downstream interpolator uses the integer parts to select the four neighbouring samples and the fractions to weight them.

The sequencer has five states:
- `ST_IDLE`: after reset.
- `ST_ANCHOR`: computes the first point of a ray.
- `ST_STREAM`: presents beats.
- `ST_TURN`: rotates the step vector for the next ray.
- `ST_DONE`: the job is complete.

Its transitions are:
- start_accept: `ST_IDLE` or `ST_DONE` to `ST_ANCHOR` on `start`.
- anchor_ready: `ST_ANCHOR` to `ST_STREAM`.
- ray_end: `ST_STREAM` to `ST_TURN` when the last sample of a ray that is not the last ray is accepted.
- job_end: `ST_STREAM` to `ST_DONE` when the last sample of the last ray is accepted.
- turn_done: `ST_TURN` to `ST_ANCHOR`.

Top module: `polar_addr_gen`

## Requirements
- R1: While reset is held, and after it is released until the first `start`, `out_valid` and `done` are 0.
- R2: A write with `cfg_we`=1 stores `cfg_wdata` into the register selected by `cfg_addr`. The register map is:
  - 0: point count N, low 10 bits.
  - 1: radius R, low 7 bits.
  - 2: initial x step.
  - 3: initial y step.
  - 4: x offset.
  - 5: cosine of the angle step.
  - 6: x cross coefficient.
  - 7: y cross coefficient.
  
  Registers 2 to 4 hold 12.16 values in all 28 bits, and registers 5 to 7 hold 2.16 values in the low 18 bits. Writes made while a job is running (state `ST_ANCHOR`, `ST_STREAM` or `ST_TURN`) are ignored.
- R3: A job emits exactly N×N beats in ray-major order. Every radial sample r = 0..N−1 of ray t comes before any sample of ray t+1. `out_dst` equals t·N + r, starting at 0 and rising by one per accepted beat.
- R4: With K = R·(N−1) and (sx, sy) the step of ray t, beat (t, r) has x = K·sx − xoff + r·sx and y = K·sy + r·sy, all taken modulo 2^28. `out_x_idx`/`out_y_idx` are bits 27:16 of x and y, and `out_x_frac`/`out_y_frac` are bits 15:0.
- R5: Ray 0 uses the steps in registers 2 and 3. For each later ray, sx' = (sx·c − sy·kx) >>> 16 and sy' = (sy·c + sx·ky) >>> 16, using signed arithmetic and truncated to 28 bits. Here c, kx and ky are registers 5, 6 and 7.
- R6: While `out_valid` is 1 and `out_ready` is 0, the next cycle still has `out_valid` at 1 with every payload field unchanged.
- R7: The block issues at most one beat per cycle. With `out_ready` held at 1, beats within a ray come on consecutive cycles, and the first beat of a ray comes 3 cycles after the last beat of the previous ray.
- R8: `done` rises on the cycle after the final beat is accepted, and it is never 1 together with `out_valid`. It stays at 1 until a `start` is sampled, and it falls on the cycle after that `start`.
- R9: A `start` pulse while a job is running is ignored; the running job continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 28 | Configuration write data |
| start | input | 1 | Begin a job (sampled when not running) |
| out_valid | output | 1 | Beat present |
| out_ready | input | 1 | Downstream accepts the beat |
| out_x_idx | output | 12 | Integer part of x |
| out_x_frac | output | 16 | Fractional part of x |
| out_y_idx | output | 12 | Integer part of y |
| out_y_frac | output | 16 | Fractional part of y |
| out_dst | output | 20 | Linear destination index t·N + r |
| done | output | 1 | Job complete, held until next start |

## Verification
The bound checker examines every cycle for four properties:
- the payload is held still during a stall;
- the destination index starts at zero and rises by exactly one from beat to beat within a job;
- `done` excludes `out_valid`;
- `done` rises only after an accepted beat and falls only after a `start`.

The fixed-point values themselves, the rotation between rays and the bubble spacing at ray boundaries are visible only to the bench. The bench compares them against a behavioural model built from the host constants. Only the bench's scenarios can show that a `start` or a register write during a running job is ignored: the job's beat count is checked, and a follow-up job that rewrites no register must reproduce the earlier configuration.

// File: rtl/polar_pkg.sv
package polar_pkg;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ANCHOR = 3'd1,
        ST_STREAM = 3'd2,
        ST_TURN   = 3'd3,
        ST_DONE   = 3'd4
    } seq_state_t;

    // Configuration register selects.
    typedef enum logic [2:0] {
        REG_COUNT   = 3'd0,
        REG_RADIUS  = 3'd1,
        REG_STEP_X  = 3'd2,
        REG_STEP_Y  = 3'd3,
        REG_X_SHIFT = 3'd4,
        REG_COS_D   = 3'd5,
        REG_CROSS_X = 3'd6,
        REG_CROSS_Y = 3'd7
    } cfg_reg_e;

endpackage

// File: rtl/polar_cfg_regs.sv
module polar_cfg_regs
    import polar_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int RAD_W  = 7,
    parameter int POS_W  = 28,
    parameter int COEF_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock,
    input  logic              we,
    input  logic [2:0]        addr,
    input  logic [POS_W-1:0]  wdata,
    output logic [CNT_W-1:0]  count_q,
    output logic [RAD_W-1:0]  radius_q,
    output logic [POS_W-1:0]  step_x0_q,
    output logic [POS_W-1:0]  step_y0_q,
    output logic [POS_W-1:0]  x_shift_q,
    output logic [COEF_W-1:0] cos_d_q,
    output logic [COEF_W-1:0] cross_x_q,
    output logic [COEF_W-1:0] cross_y_q
);

    // Writes land only while no job is running.
    logic wr_en;
    assign wr_en = we && !lock;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q   <= '0;
            radius_q  <= '0;
            step_x0_q <= '0;
            step_y0_q <= '0;
            x_shift_q <= '0;
            cos_d_q   <= '0;
            cross_x_q <= '0;
            cross_y_q <= '0;
        end else if (wr_en) begin
            unique case (cfg_reg_e'(addr))
                REG_COUNT:   count_q   <= wdata[CNT_W-1:0];
                REG_RADIUS:  radius_q  <= wdata[RAD_W-1:0];
                REG_STEP_X:  step_x0_q <= wdata;
                REG_STEP_Y:  step_y0_q <= wdata;
                REG_X_SHIFT: x_shift_q <= wdata;
                REG_COS_D:   cos_d_q   <= wdata[COEF_W-1:0];
                REG_CROSS_X: cross_x_q <= wdata[COEF_W-1:0];
                REG_CROSS_Y: cross_y_q <= wdata[COEF_W-1:0];
                default:     ;
            endcase
        end
    end

endmodule

// File: rtl/polar_axis.sv
module polar_axis #(
    parameter int POS_W     = 28,
    parameter int COEF_W    = 18,
    parameter int RK_W      = 17,
    parameter int FRAC_W    = 16,
    parameter bit CROSS_NEG = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              turn,
    input  logic              anchor,
    input  logic              step,
    input  logic [POS_W-1:0]  init_step,
    input  logic [POS_W-1:0]  cross_step,
    input  logic [COEF_W-1:0] cos_d,
    input  logic [COEF_W-1:0] cross_k,
    input  logic [RK_W-1:0]   rk,
    input  logic [POS_W-1:0]  shift,
    output logic [POS_W-1:0]  step_q,
    output logic [POS_W-1:0]  pos_q
);

    localparam int PROD_W = POS_W + COEF_W + 2;

    logic signed [PROD_W-1:0] own_ext, oth_ext, cos_ext, k_ext;
    logic signed [PROD_W-1:0] own_p, oth_p, rot_sum;
    logic [POS_W-1:0]         rot_next, anchor_pos;

    // Per-ray rotation (angle-addition recurrence).
    always_comb begin
        own_ext  = $signed(PROD_W'(step_q));
        oth_ext  = $signed(PROD_W'(cross_step));
        cos_ext  = $signed(PROD_W'(cos_d));
        k_ext    = $signed(PROD_W'(cross_k));
        own_p    = own_ext * cos_ext;
        oth_p    = oth_ext * k_ext;
        rot_sum  = CROSS_NEG ? (own_p - oth_p) : (own_p + oth_p);
        rot_next = POS_W'(rot_sum >>> FRAC_W);
    end

    // First point of a ray: one multiply, modulo the position width.
    assign anchor_pos = POS_W'(rk) * step_q - shift;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            pos_q  <= '0;
        end else begin
            if (load) begin
                step_q <= init_step;
            end else if (turn) begin
                step_q <= rot_next;
            end
            if (anchor) begin
                pos_q <= anchor_pos;
            end else if (step) begin
                pos_q <= pos_q + step_q;
            end
        end
    end

endmodule

// File: rtl/polar_seq.sv
module polar_seq
    import polar_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int RAD_W = 7,
    parameter int RK_W  = CNT_W + RAD_W,
    parameter int DST_W = 2 * CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             out_ready,
    input  logic [CNT_W-1:0] count_cfg,
    input  logic [RAD_W-1:0] radius_cfg,
    output logic             load,
    output logic             anchor,
    output logic             step,
    output logic             turn,
    output logic             busy,
    output logic             out_valid,
    output logic             done,
    output logic [RK_W-1:0]  rk_q,
    output logic [DST_W-1:0] dst_q
);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] last_q, r_q, t_q;
    logic             fire, ray_end, job_end;

    assign fire    = (state_q == ST_STREAM) && out_ready;
    assign ray_end = fire && (r_q == last_q);
    assign job_end = ray_end && (t_q == last_q);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: if (start) state_d = ST_ANCHOR;
            ST_ANCHOR:        state_d = ST_STREAM;
            ST_STREAM: begin
                if (job_end) begin
                    state_d = ST_DONE;
                end else if (ray_end) begin
                    state_d = ST_TURN;
                end
            end
            ST_TURN:          state_d = ST_ANCHOR;
            default:          state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state.
    always_comb begin
        load      = 1'b0;
        anchor    = 1'b0;
        step      = 1'b0;
        turn      = 1'b0;
        busy      = 1'b0;
        out_valid = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:   load = start;
            ST_DONE: begin
                load = start;
                done = 1'b1;
            end
            ST_ANCHOR: begin
                anchor = 1'b1;
                busy   = 1'b1;
            end
            ST_STREAM: begin
                out_valid = 1'b1;
                busy      = 1'b1;
                step      = fire && !ray_end;
            end
            ST_TURN: begin
                turn = 1'b1;
                busy = 1'b1;
            end
            default: ;
        endcase
    end

    // Loop counters and job constants.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
            r_q    <= '0;
            t_q    <= '0;
            rk_q   <= '0;
            dst_q  <= '0;
        end else if (load) begin
            last_q <= count_cfg - CNT_W'(1);
            rk_q   <= RK_W'(radius_cfg) * RK_W'(count_cfg - CNT_W'(1));
            r_q    <= '0;
            t_q    <= '0;
            dst_q  <= '0;
        end else if (fire) begin
            dst_q <= dst_q + DST_W'(1);
            if (ray_end) begin
                r_q <= '0;
                t_q <= t_q + CNT_W'(1);
            end else begin
                r_q <= r_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/polar_addr_gen.sv
module polar_addr_gen
    import polar_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int RAD_W  = 7,
    parameter int INT_W  = 12,
    parameter int FRAC_W = 16,
    parameter int COEF_W = FRAC_W + 2,
    parameter int POS_W  = INT_W + FRAC_W,
    parameter int DST_W  = 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [POS_W-1:0]  cfg_wdata,
    input  logic              start,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [INT_W-1:0]  out_x_idx,
    output logic [FRAC_W-1:0] out_x_frac,
    output logic [INT_W-1:0]  out_y_idx,
    output logic [FRAC_W-1:0] out_y_frac,
    output logic [DST_W-1:0]  out_dst,
    output logic              done
);

    localparam int RK_W = CNT_W + RAD_W;

    logic [CNT_W-1:0]  count_q;
    logic [RAD_W-1:0]  radius_q;
    logic [POS_W-1:0]  step_x0_q, step_y0_q, x_shift_q;
    logic [COEF_W-1:0] cos_d_q, cross_x_q, cross_y_q;
    logic              load, anchor, step, turn, busy;
    logic [RK_W-1:0]   rk_q;

    logic [POS_W-1:0]  init_a  [2];
    logic [POS_W-1:0]  shift_a [2];
    logic [COEF_W-1:0] cross_a [2];
    logic [POS_W-1:0]  step_a  [2];
    logic [POS_W-1:0]  pos_a   [2];

    polar_cfg_regs #(
        .CNT_W(CNT_W), .RAD_W(RAD_W), .POS_W(POS_W), .COEF_W(COEF_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .lock(busy),
        .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .count_q(count_q), .radius_q(radius_q),
        .step_x0_q(step_x0_q), .step_y0_q(step_y0_q), .x_shift_q(x_shift_q),
        .cos_d_q(cos_d_q), .cross_x_q(cross_x_q), .cross_y_q(cross_y_q)
    );

    polar_seq #(
        .CNT_W(CNT_W), .RAD_W(RAD_W), .RK_W(RK_W), .DST_W(DST_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .out_ready(out_ready),
        .count_cfg(count_q), .radius_cfg(radius_q),
        .load(load), .anchor(anchor), .step(step), .turn(turn), .busy(busy),
        .out_valid(out_valid), .done(done), .rk_q(rk_q), .dst_q(out_dst)
    );

    assign init_a[0]  = step_x0_q;
    assign init_a[1]  = step_y0_q;
    assign shift_a[0] = x_shift_q;
    assign shift_a[1] = '0;
    assign cross_a[0] = cross_x_q;
    assign cross_a[1] = cross_y_q;

    // Axis 0 is x (cross term subtracted), axis 1 is y (cross term added).
    for (genvar i = 0; i < 2; i++) begin : g_axis
        polar_axis #(
            .POS_W(POS_W), .COEF_W(COEF_W), .RK_W(RK_W), .FRAC_W(FRAC_W),
            .CROSS_NEG(i == 0)
        ) u_axis (
            .clk(clk), .rst_n(rst_n),
            .load(load), .turn(turn), .anchor(anchor), .step(step),
            .init_step(init_a[i]), .cross_step(step_a[1-i]),
            .cos_d(cos_d_q), .cross_k(cross_a[i]),
            .rk(rk_q), .shift(shift_a[i]),
            .step_q(step_a[i]), .pos_q(pos_a[i])
        );
    end

    assign out_x_idx  = pos_a[0][POS_W-1:FRAC_W];
    assign out_x_frac = pos_a[0][FRAC_W-1:0];
    assign out_y_idx  = pos_a[1][POS_W-1:FRAC_W];
    assign out_y_frac = pos_a[1][FRAC_W-1:0];

endmodule

// File: rtl/polar_addr_gen_chk.sv
module polar_addr_gen_chk #(
    parameter int CNT_W  = 10,
    parameter int INT_W  = 12,
    parameter int FRAC_W = 16,
    parameter int DST_W  = 2 * CNT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              out_valid,
    input logic              out_ready,
    input logic [INT_W-1:0]  out_x_idx,
    input logic [FRAC_W-1:0] out_x_frac,
    input logic [INT_W-1:0]  out_y_idx,
    input logic [FRAC_W-1:0] out_y_frac,
    input logic [DST_W-1:0]  out_dst,
    input logic              done
);

    logic [DST_W-1:0] prev_dst;
    logic             have_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_dst  <= '0;
            have_prev <= 1'b0;
        end else if (done) begin
            have_prev <= 1'b0;
        end else if (out_valid && out_ready) begin
            prev_dst  <= out_dst;
            have_prev <= 1'b1;
        end
    end

    // R6: stalled beat keeps every field
    a_r6_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_x_idx) && $stable(out_x_frac)
            && $stable(out_y_idx) && $stable(out_y_frac) && $stable(out_dst));

    // R3: destination index starts at zero in each job
    a_r3_first_dst: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !have_prev |-> out_dst == '0);

    // R3: destination index rises by one per accepted beat
    a_r3_dst_step: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && have_prev |-> out_dst == prev_dst + DST_W'(1));

    // R8: done never overlaps a beat
    a_r8_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);

    // R8: done rises only after an accepted beat
    a_r8_done_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(out_valid && out_ready));

    // R8: done falls only after a start
    a_r8_done_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> $past(start));

endmodule

bind polar_addr_gen polar_addr_gen_chk #(
    .CNT_W(CNT_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .DST_W(DST_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_x_idx(out_x_idx), .out_x_frac(out_x_frac),
    .out_y_idx(out_y_idx), .out_y_frac(out_y_frac),
    .out_dst(out_dst), .done(done)
);

// File: tb/sim_polar_addr_gen.sv
module sim_polar_addr_gen;

    localparam int CLK_PERIOD = 10;
    localparam int POS_W = 28;
    localparam longint MASK = (longint'(1) << POS_W) - 1;
    localparam real PI = 3.14159265358979;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [27:0] cfg_wdata = '0;
    logic        start = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [11:0] out_x_idx, out_y_idx;
    logic [15:0] out_x_frac, out_y_frac;
    logic [19:0] out_dst;
    logic        done;

    always #(CLK_PERIOD/2) clk = ~clk;

    polar_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .start(start), .out_valid(out_valid),
        .out_ready(out_ready), .out_x_idx(out_x_idx), .out_x_frac(out_x_frac),
        .out_y_idx(out_y_idx), .out_y_frac(out_y_frac), .out_dst(out_dst),
        .done(done)
    );

    typedef struct {
        longint px;
        longint py;
        longint dst;
    } beat_t;

    int     n_checks = 0;
    int     n_fails  = 0;
    longint cyc = 0;
    longint cv [8];
    beat_t  exp_q [$];
    int     ready_mode = 0;
    bit     strict_gap = 1'b0;
    longint cur_n = 10;
    longint prev_cyc = 0;
    int     beats_seen = 0;
    bit     stall_seen = 1'b0;
    beat_t  stall_beat;
    bit     last_pending = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Ready pattern: 0 always high, 1 pseudo-random, 2 alternating.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            case (ready_mode)
                0: out_ready = 1'b1;
                1: begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    out_ready = lfsr[0] | lfsr[3];
                end
                default: out_ready = ~out_ready;
            endcase
        end
    end

    // Monitor: compares every accepted beat with the model.
    always @(negedge clk) begin
        if (rst_n) begin
            if (last_pending) begin
                check(done == 1'b1, "R8", "done after final accept", longint'(done), 1);
                last_pending = 1'b0;
            end
            if (out_valid) begin
                beat_t cur;
                cur.px  = longint'({out_x_idx, out_x_frac});
                cur.py  = longint'({out_y_idx, out_y_frac});
                cur.dst = longint'(out_dst);
                if (stall_seen) begin
                    check(cur.px == stall_beat.px && cur.py == stall_beat.py
                          && cur.dst == stall_beat.dst, "R6", "stalled beat held",
                          cur.dst, stall_beat.dst);
                end
                if (out_ready) begin
                    stall_seen = 1'b0;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R3", "unexpected extra beat", cur.dst, -1);
                    end else begin
                        beat_t e;
                        e = exp_q.pop_front();
                        check(cur.dst == e.dst, "R3", "destination index", cur.dst, e.dst);
                        check(cur.px == e.px, "R4 R5", "x position", cur.px, e.px);
                        check(cur.py == e.py, "R4 R5", "y position", cur.py, e.py);
                        if (strict_gap && beats_seen > 0) begin
                            longint g;
                            g = (e.dst % cur_n == 0) ? 3 : 1;
                            check(cyc - prev_cyc == g, "R7", "beat spacing", cyc - prev_cyc, g);
                        end
                        if (exp_q.size() == 0) begin
                            check(done == 1'b0, "R8", "done low at final accept", longint'(done), 0);
                            last_pending = 1'b1;
                        end
                    end
                    prev_cyc = cyc;
                    beats_seen++;
                end else begin
                    stall_seen = 1'b1;
                    stall_beat = cur;
                end
            end
        end
    end

    task automatic write_reg(input int a, input longint v);
        @(posedge clk);
        #1;
        cfg_we    = 1'b1;
        cfg_addr  = 3'(a);
        cfg_wdata = 28'(v);
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(posedge clk);
        #1;
        start = 1'b1;
        @(posedge clk);
        #1;
        start = 1'b0;
    endtask

    task automatic make_cfg(input int n, input int rad, input real th);
        real dxs, dys, dth;
        dxs = (rad + 1.0) - rad * $cos(th);
        dys = (rad + 1.0) * $sin(th);
        dth = th / (n - 1);
        cv[0] = n;
        cv[1] = rad;
        cv[2] = longint'($rtoi(65536.0 / dxs + 0.5));
        cv[3] = 0;
        cv[4] = longint'($rtoi(rad * $cos(th) * (n - 1) / dxs * 65536.0 + 0.5)) - 4096;
        cv[5] = longint'($rtoi($cos(dth) * 65536.0 + 0.5));
        cv[6] = longint'($rtoi($sin(dth) * dys / dxs * 65536.0 + 0.5));
        cv[7] = longint'($rtoi($sin(dth) * dxs / dys * 65536.0 + 0.5));
    endtask

    // Behavioural model: builds the expected beat list from cv.
    task automatic build_model();
        longint n, rk, sx, sy, px, py, nx, ny;
        beat_t b;
        n  = cv[0];
        rk = cv[1] * (n - 1);
        sx = cv[2];
        sy = cv[3];
        exp_q.delete();
        for (longint t = 0; t < n; t++) begin
            if (t > 0) begin
                nx = (sx * cv[5] - sy * cv[6]) >>> 16;
                ny = (sy * cv[5] + sx * cv[7]) >>> 16;
                sx = nx & MASK;
                sy = ny & MASK;
            end
            px = (rk * sx - cv[4]) & MASK;
            py = (rk * sy) & MASK;
            for (longint r = 0; r < n; r++) begin
                b.px  = px;
                b.py  = py;
                b.dst = t * n + r;
                exp_q.push_back(b);
                px = (px + sx) & MASK;
                py = (py + sy) & MASK;
            end
        end
    endtask

    task automatic run_job(input bit do_write, input int n, input int rad, input real th,
                           input int mode, input bit poke);
        if (do_write) begin
            make_cfg(n, rad, th);
            for (int a = 0; a < 8; a++) write_reg(a, cv[a]);
        end
        build_model();
        cur_n      = cv[0];
        beats_seen = 0;
        stall_seen = 1'b0;
        ready_mode = mode;
        strict_gap = (mode == 0);
        pulse_start();
        @(negedge clk);
        check(done == 1'b0, "R8", "done cleared after start", longint'(done), 0);
        if (poke) begin
            repeat (15) @(posedge clk);
            pulse_start();
            write_reg(0, 20);
            write_reg(2, 12345);
        end
        while (!done) @(negedge clk);
        check(exp_q.size() == 0, "R3", "beats left unissued", exp_q.size(), 0);
        check(beats_seen == cv[0] * cv[0], poke ? "R9" : "R3", "beat count",
              beats_seen, cv[0] * cv[0]);
        repeat (3) @(negedge clk);
        check(done == 1'b1, "R8", "done held", longint'(done), 1);
        check(out_valid == 1'b0, "R8", "no beat while done", longint'(out_valid), 0);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected 0", cyc);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "valid in reset", longint'(out_valid), 0);
        check(done == 1'b0, "R1", "done in reset", longint'(done), 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R1", "valid before start", longint'(out_valid), 0);
        check(done == 1'b0, "R1", "done before start", longint'(done), 0);

        // R4 R5 R7: full-rate job at the widest sweep
        run_job(1'b1, 10, 10, PI / 4.0, 0, 1'b0);
        // R9 R2: random backpressure, start and writes during the job
        run_job(1'b1, 13, 37, PI / 8.0, 1, 1'b1);
        // R2: no rewrite, so the earlier configuration must repeat
        run_job(1'b0, 13, 37, PI / 8.0, 2, 1'b0);
        // narrow sweep, largest radius, longer rays
        run_job(1'b1, 40, 100, PI / 256.0, 0, 1'b0);
        run_job(1'b1, 10, 100, PI / 4.0, 1, 1'b0);

        summary();
        $finish;
    end

endmodule